// File: doc/BRIEF.md
# I2C Master FIFO Threshold and Drain Event Logic

This block holds the transmit and receive byte queues of an I2C master controller and decides when software must be told to refill the transmit queue or empty the receive queue. It compares each queue's fill level against a programmable threshold and against the number of bytes the current transfer still owes. When a whole threshold's worth of work remains, it raises a "ready" event. When the tail of the transfer is shorter than the threshold, it raises a separate "drain" event, so the last few bytes are always signalled.

The register interface pushes transmit bytes and pops receive bytes. The serial shift engine pops transmit bytes and pushes receive bytes. A transfer-start pulse loads the byte count and the direction. Events are one-cycle pulses. After an event fires, no new event is raised until software acknowledges it with a clear pulse. The queue depth is reported as a code n, meaning 8 << n bytes.

Top module: `i2c_fifo_evt`

## Requirements
- R1: The transmit threshold is `cfg_buf[5:0] + 1` and the receive threshold is `cfg_buf[13:8] + 1`, so each threshold lies between 1 and 64.
- R2: A `cfg_wr` pulse with `cfg_buf[6]` set empties the transmit queue, and one with `cfg_buf[14]` set empties the receive queue. A flush takes priority over a push or pop in the same cycle.
- R3: `xfer_start` loads the remaining-byte counter from `xfer_cnt` and latches the direction (`xfer_tx` = 1 means transmit). In transmit mode the counter decrements on each accepted transmit push; in receive mode it decrements on each accepted receive pop. It never goes below zero.
- R4: In transmit mode, `evt_xrdy` fires when the transmit level is below the transmit threshold and the remaining count is at least that threshold.
- R5: In transmit mode, `evt_xdr` fires instead when the transmit level is below the threshold and the remaining count is nonzero but smaller than the threshold. Neither transmit event fires when the remaining count is zero.
- R6: In receive mode, `evt_rrdy` fires when the receive level has reached the receive threshold.
- R7: In receive mode, `evt_rdr` fires when the receive level is nonzero, below the threshold, and equal to the remaining count, meaning the final bytes have all arrived.
- R8: Every event is a single-cycle pulse, and at most one of the four is high at a time. Once an event has fired, no further event fires until an `evt_ack` pulse arrives. `xfer_start` also discards a pending acknowledge wait.
- R9: A push into a full queue, or a pop from an empty queue, is ignored and leaves the queue contents unchanged. Such an access sets `fifo_err`, which stays set until the next `xfer_start`.
- R10: Each queue returns bytes in the order they were pushed. The read data shows the oldest byte before it is popped. Each queue holds 8 << `DEPTH_CODE` bytes, and `fifo_depth_code` reports `DEPTH_CODE`.
- R11: After reset, no event is high, both queues are empty, `fifo_err` is 0 and the remaining count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_buf | input | 16 | Buffer configuration: thresholds and flush bits |
| cfg_wr | input | 1 | Write strobe for the flush bits in cfg_buf |
| xfer_cnt | input | CNT_W | Number of bytes in the transfer |
| xfer_start | input | 1 | Transfer-start pulse |
| xfer_tx | input | 1 | Direction at start: 1 = transmit, 0 = receive |
| tx_push | input | 1 | Register-side push into the transmit queue |
| tx_wdata | input | 8 | Byte pushed into the transmit queue |
| tx_pop | input | 1 | Shift-engine pop from the transmit queue |
| tx_rdata | output | 8 | Oldest byte in the transmit queue |
| rx_push | input | 1 | Shift-engine push into the receive queue |
| rx_wdata | input | 8 | Byte pushed into the receive queue |
| rx_pop | input | 1 | Register-side pop from the receive queue |
| rx_rdata | output | 8 | Oldest byte in the receive queue |
| evt_ack | input | 1 | Software acknowledge of the last event |
| evt_xrdy | output | 1 | Transmit-ready event pulse |
| evt_xdr | output | 1 | Transmit-drain event pulse |
| evt_rrdy | output | 1 | Receive-ready event pulse |
| evt_rdr | output | 1 | Receive-drain event pulse |
| fifo_err | output | 1 | Sticky flag for an overflow or underflow access |
| fifo_depth_code | output | 3 | Queue depth code n (depth = 8 << n) |

## Verification
The transmit path is run with a ten-byte transfer against a threshold of four. The early refill requests must come out as ready events, and the request raised once only two bytes remain must come out as a drain event. This shows that the remaining count, not the queue level alone, picks the event. A five-byte receive transfer with a threshold of three checks two things: a full threshold gives a ready event, and a partial tail of two gives a drain event only once the tail is completely present.

Threshold one with a single byte tells the ready case apart from the drain case at the boundary where the remaining count equals the threshold. Further runs cover four cases:
- a flush that makes the transmit refill request reappear;
- filling a queue past its depth, where the ordered read-back shows the overflowing byte was dropped;
- popping an empty queue;
- holding off acknowledges, which shows that no event repeats while one is unserviced.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

  localparam int CFG_W      = 16;
  localparam int TRSH_W     = 6;
  localparam int TX_TRSH_LSB = 0;
  localparam int RX_TRSH_LSB = 8;
  localparam int TX_CLR_BIT = 6;
  localparam int RX_CLR_BIT = 14;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic xrdy;
    logic xdr;
    logic rrdy;
    logic rdr;
  } evt_vec_t;

endpackage

// File: rtl/i2c_fifo_rst_sync.sv
module i2c_fifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf #(
  parameter int DATA_W     = 8,
  parameter int DEPTH_CODE = 1,
  localparam int DEPTH     = 8 << DEPTH_CODE,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int LVL_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [LVL_W-1:0]  level,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              bad_op
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic              full, empty;

  assign full  = (lvl_q == LVL_W'(DEPTH));
  assign empty = (lvl_q == '0);

  always_comb begin
    push_ok  = push && !full  && !flush;
    pop_ok   = pop  && !empty && !flush;
    bad_op   = !flush && ((push && full) || (pop && empty));
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    lvl_d    = lvl_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      lvl_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = wr_ptr_q + PTR_W'(1);
      if (pop_ok)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
      case ({push_ok, pop_ok})
        2'b10:   lvl_d = lvl_q + LVL_W'(1);
        2'b01:   lvl_d = lvl_q - LVL_W'(1);
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      lvl_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      lvl_q    <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign level = lvl_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH)); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (lvl_q == '0)); // R2
  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (lvl_q == $past(lvl_q))); // R9

endmodule

// File: rtl/i2c_fifo_remain.sv
module i2c_fifo_remain #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_load,
  input  logic             dec,
  output logic [CNT_W-1:0] remain
);

  logic [CNT_W-1:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (start)                   rem_d = cnt_load;
    else if (dec && rem_q != '0) rem_d = rem_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign remain = rem_q;

  AST_REM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem_q == $past(cnt_load))); // R3
  AST_REM_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (rem_q <= $past(rem_q))); // R3

endmodule

// File: rtl/i2c_fifo_evtgen.sv
module i2c_fifo_evtgen
  import i2c_fifo_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 5,
  localparam int THR_W = TRSH_W + 1,
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_dir_e        dir,
  input  logic             start,
  input  logic             ack,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [THR_W-1:0] tx_thr,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [CNT_W-1:0] remain,
  output evt_vec_t         evt
);

  evt_vec_t   evt_q, evt_d;
  logic       busy_q, busy_d;
  logic [CMP_W-1:0] txl, rxl, txt, rxt, rem;
  logic       tx_low, rx_full;

  assign txl = CMP_W'(tx_level);
  assign rxl = CMP_W'(rx_level);
  assign txt = CMP_W'(tx_thr);
  assign rxt = CMP_W'(rx_thr);
  assign rem = CMP_W'(remain);

  always_comb begin
    tx_low  = (txl < txt);
    rx_full = (rxl >= rxt);
    evt_d   = '0;
    if (!busy_q && !start) begin
      if (dir == DIR_TX) begin
        evt_d.xrdy = tx_low && (rem >= txt);
        evt_d.xdr  = tx_low && (rem != '0) && (rem < txt);
      end else begin
        evt_d.rrdy = rx_full;
        evt_d.rdr  = !rx_full && (rxl != '0) && (rxl == rem);
      end
    end
    if (start)        busy_d = 1'b0;
    else if (|evt_d)  busy_d = 1'b1;
    else if (ack)     busy_d = 1'b0;
    else              busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      busy_q <= busy_d;
    end
  end

  assign evt = evt_q;

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(evt_q) <= 1); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_q) |=> !(|evt_q)); // R8
  AST_WAIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack) |=> !(|evt_q)); // R8
  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q.xrdy || evt_q.xdr) |-> $past(dir == DIR_TX)); // R4

endmodule

// File: rtl/i2c_fifo_evt.sv
module i2c_fifo_evt
  import i2c_fifo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEPTH_CODE = 1,
  parameter int DCODE_W    = 3,
  localparam int DATA_W    = 8,
  localparam int DEPTH     = 8 << DEPTH_CODE,
  localparam int LVL_W     = $clog2(DEPTH) + 1,
  localparam int THR_W     = TRSH_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_buf,
  input  logic               cfg_wr,
  input  logic [CNT_W-1:0]   xfer_cnt,
  input  logic               xfer_start,
  input  logic               xfer_tx,
  input  logic               tx_push,
  input  logic [DATA_W-1:0]  tx_wdata,
  input  logic               tx_pop,
  output logic [DATA_W-1:0]  tx_rdata,
  input  logic               rx_push,
  input  logic [DATA_W-1:0]  rx_wdata,
  input  logic               rx_pop,
  output logic [DATA_W-1:0]  rx_rdata,
  input  logic               evt_ack,
  output logic               evt_xrdy,
  output logic               evt_xdr,
  output logic               evt_rrdy,
  output logic               evt_rdr,
  output logic               fifo_err,
  output logic [DCODE_W-1:0] fifo_depth_code
);

  logic             rst_q_n;
  logic             tx_flush, rx_flush;
  logic [LVL_W-1:0] tx_level, rx_level;
  logic             tx_push_ok, tx_pop_ok, tx_bad;
  logic             rx_push_ok, rx_pop_ok, rx_bad;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [CNT_W-1:0] remain;
  logic             rem_dec;
  xfer_dir_e        dir_q, dir_d;
  logic             err_q, err_d;
  evt_vec_t         evt;

  i2c_fifo_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n)
  );

  assign tx_flush = cfg_wr && cfg_buf[TX_CLR_BIT];
  assign rx_flush = cfg_wr && cfg_buf[RX_CLR_BIT];
  assign tx_thr   = THR_W'(cfg_buf[TX_TRSH_LSB +: TRSH_W]) + THR_W'(1);
  assign rx_thr   = THR_W'(cfg_buf[RX_TRSH_LSB +: TRSH_W]) + THR_W'(1);

  i2c_fifo_buf #(.DATA_W(DATA_W), .DEPTH_CODE(DEPTH_CODE)) u_txq (
    .clk(clk), .rst_n(rst_q_n), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .level(tx_level), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .bad_op(tx_bad)
  );

  i2c_fifo_buf #(.DATA_W(DATA_W), .DEPTH_CODE(DEPTH_CODE)) u_rxq (
    .clk(clk), .rst_n(rst_q_n), .flush(rx_flush),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .level(rx_level), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .bad_op(rx_bad)
  );

  always_comb begin
    dir_d   = xfer_start ? (xfer_tx ? DIR_TX : DIR_RX) : dir_q;
    rem_dec = (dir_q == DIR_TX) ? tx_push_ok : rx_pop_ok;
    if (xfer_start)             err_d = 1'b0;
    else if (tx_bad || rx_bad)  err_d = 1'b1;
    else                        err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      dir_q <= DIR_RX;
      err_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      err_q <= err_d;
    end
  end

  i2c_fifo_remain #(.CNT_W(CNT_W)) u_rem (
    .clk(clk), .rst_n(rst_q_n), .start(xfer_start),
    .cnt_load(xfer_cnt), .dec(rem_dec), .remain(remain)
  );

  i2c_fifo_evtgen #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_evt (
    .clk(clk), .rst_n(rst_q_n), .dir(dir_q), .start(xfer_start),
    .ack(evt_ack), .tx_level(tx_level), .rx_level(rx_level),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .remain(remain), .evt(evt)
  );

  assign evt_xrdy        = evt.xrdy;
  assign evt_xdr         = evt.xdr;
  assign evt_rrdy        = evt.rrdy;
  assign evt_rdr         = evt.rdr;
  assign fifo_err        = err_q;
  assign fifo_depth_code = DCODE_W'(DEPTH_CODE);

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(err_q) |-> $past(tx_bad || rx_bad)); // R9
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    xfer_start |=> !err_q); // R9

endmodule

// File: tb/test_i2c_fifo_evt.sv
module test_i2c_fifo_evt;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_buf;
  logic        cfg_wr;
  logic [15:0] xfer_cnt;
  logic        xfer_start, xfer_tx;
  logic        tx_push, tx_pop, rx_push, rx_pop, evt_ack;
  logic [7:0]  tx_wdata, rx_wdata, tx_rdata, rx_rdata;
  logic        evt_xrdy, evt_xdr, evt_rrdy, evt_rdr, fifo_err;
  logic [2:0]  fifo_depth_code;

  int checks = 0;
  int errors = 0;
  int n_xrdy = 0, n_xdr = 0, n_rrdy = 0, n_rdr = 0;

  always #5 clk = ~clk;

  i2c_fifo_evt i_i2c_fifo_evt (
    .clk(clk), .rst_n(rst_n), .cfg_buf(cfg_buf), .cfg_wr(cfg_wr),
    .xfer_cnt(xfer_cnt), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .evt_ack(evt_ack), .evt_xrdy(evt_xrdy), .evt_xdr(evt_xdr),
    .evt_rrdy(evt_rrdy), .evt_rdr(evt_rdr), .fifo_err(fifo_err),
    .fifo_depth_code(fifo_depth_code)
  );

  always @(negedge clk) begin
    if (evt_xrdy) n_xrdy++;
    if (evt_xdr)  n_xdr++;
    if (evt_rrdy) n_rrdy++;
    if (evt_rdr)  n_rdr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_evts(input string req, input int x, input int xd, input int r, input int rd);
    chk(n_xrdy == x,  {req, " xrdy count"}, n_xrdy, x);
    chk(n_xdr  == xd, {req, " xdr count"},  n_xdr,  xd);
    chk(n_rrdy == r,  {req, " rrdy count"}, n_rrdy, r);
    chk(n_rdr  == rd, {req, " rdr count"},  n_rdr,  rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_counts;
    n_xrdy = 0; n_xdr = 0; n_rrdy = 0; n_rdr = 0;
  endtask

  task automatic cfg(input int txt, input int rxt, input bit txclr, input bit rxclr);
    @(negedge clk);
    cfg_buf = '0;
    cfg_buf[5:0]  = 6'(txt - 1);
    cfg_buf[13:8] = 6'(rxt - 1);
    cfg_buf[6]    = txclr;
    cfg_buf[14]   = rxclr;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic start(input int cnt, input bit tx);
    @(negedge clk);
    xfer_cnt = 16'(cnt); xfer_tx = tx; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_wdata = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_wdata = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(tx_rdata == exp, req, tx_rdata, exp);
    tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string req);
    @(negedge clk);
    chk(rx_rdata == exp, req, rx_rdata, exp);
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic t_reset;
    chk(fifo_err == 1'b0, "R11 err after reset", fifo_err, 0);
    chk({evt_xrdy, evt_xdr, evt_rrdy, evt_rdr} == 4'b0, "R11 events after reset",
        {evt_xrdy, evt_xdr, evt_rrdy, evt_rdr}, 0);
    chk(fifo_depth_code == 3'd1, "R10 depth code", fifo_depth_code, 1);
    chk_evts("R11", 0, 0, 0, 0);
    @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    idle(1);
    chk(fifo_err == 1'b1, "R11 rx queue empty after reset", fifo_err, 1);
  endtask

  task automatic t_tx_flow;
    cfg(4, 4, 1, 1);
    clr_counts();
    start(10, 1);
    idle(3);
    chk_evts("R4 first refill", 1, 0, 0, 0);
    idle(4);
    chk_evts("R8 no repeat without ack", 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) push_tx(8'hA0 + 8'(i));
    ack();
    idle(3);
    chk_evts("R4 level at threshold", 1, 0, 0, 0);
    pop_tx(8'hA0, "R10 tx order");
    idle(2);
    chk_evts("R4 refill with 6 remaining", 2, 0, 0, 0);
    for (int i = 4; i < 8; i++) push_tx(8'hA0 + 8'(i));
    ack();
    idle(2);
    for (int i = 1; i < 5; i++) pop_tx(8'hA0 + 8'(i), "R10 tx order");
    idle(2);
    chk_evts("R5 drain with 2 remaining", 2, 1, 0, 0);
    push_tx(8'hA8); push_tx(8'hA9);
    ack();
    idle(3);
    chk_evts("R3 count exhausted", 2, 1, 0, 0);
  endtask

  task automatic t_rx_flow;
    cfg(4, 3, 1, 1);
    clr_counts();
    start(5, 0);
    idle(3);
    chk_evts("R7 nothing before data", 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) push_rx(8'h50 + 8'(i));
    idle(2);
    chk_evts("R6 threshold reached", 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) pop_rx(8'h50 + 8'(i), "R10 rx order");
    ack();
    push_rx(8'h53);
    idle(3);
    chk_evts("R7 partial tail not complete", 0, 0, 1, 0);
    push_rx(8'h54);
    idle(2);
    chk_evts("R7 tail complete", 0, 0, 1, 1);
    pop_rx(8'h53, "R10 rx order"); pop_rx(8'h54, "R10 rx order");
    ack();
    idle(3);
    chk_evts("R3 rx count exhausted", 0, 0, 1, 1);
  endtask

  task automatic t_thr_one;
    cfg(1, 1, 1, 1);
    clr_counts();
    start(1, 1);
    idle(3);
    chk_evts("R1 R4 threshold one equals remaining", 1, 0, 0, 0);
    push_tx(8'h11);
    ack();
    pop_tx(8'h11, "R10 single byte");
    idle(3);
    chk_evts("R5 no drain when remaining is zero", 1, 0, 0, 0);
  endtask

  task automatic t_flush;
    cfg(2, 4, 1, 1);
    clr_counts();
    start(4, 1);
    idle(3);
    push_tx(8'h21); push_tx(8'h22);
    ack();
    idle(3);
    chk_evts("R2 before flush", 1, 0, 0, 0);
    cfg(2, 4, 1, 0);
    idle(2);
    chk_evts("R2 flush empties tx queue", 2, 0, 0, 0);
    start(8, 0);
    push_rx(8'h31); push_rx(8'h32);
    cfg(2, 4, 0, 1);
    chk(fifo_err == 1'b0, "R2 err clear before rx pop", fifo_err, 0);
    @(negedge clk); rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
    idle(1);
    chk(fifo_err == 1'b1, "R2 rx queue empty after flush", fifo_err, 1);
  endtask

  task automatic t_overflow;
    cfg(4, 4, 1, 1);
    start(1, 0);
    idle(1);
    chk(fifo_err == 1'b0, "R9 start clears err", fifo_err, 1'b0);
    for (int i = 0; i < 16; i++) push_tx(8'h60 + 8'(i));
    idle(1);
    chk(fifo_err == 1'b0, "R10 depth 16 accepted", fifo_err, 0);
    push_tx(8'hEE);
    idle(1);
    chk(fifo_err == 1'b1, "R9 overflow sets err", fifo_err, 1);
    for (int i = 0; i < 16; i++) pop_tx(8'h60 + 8'(i), "R9 overflow byte dropped");
    idle(1);
    chk(fifo_err == 1'b1, "R9 err sticky", fifo_err, 1);
    start(1, 0);
    idle(1);
    chk(fifo_err == 1'b0, "R9 err cleared by start", fifo_err, 0);
    @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    idle(1);
    chk(fifo_err == 1'b1, "R9 underflow sets err", fifo_err, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_buf = '0; cfg_wr = 1'b0; xfer_cnt = '0; xfer_start = 1'b0; xfer_tx = 1'b0;
    tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; evt_ack = 1'b0;
    tx_wdata = '0; rx_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_tx_flow();
    t_rx_flow();
    t_thr_one();
    t_flush();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule